// File: doc/BRIEF.md
# Mutual Comparator for Parallel Memory Self-Test

This block checks responses when several identical memory arrays are self-tested together. One command and address stream drives every array in the same cycle, so a healthy set of arrays returns the same word from each. The block takes one read word per array. It does not compare those words with a stored or generated golden value. Instead, it builds a reference from the arrays themselves and charges any disagreement to the array that deviates.

For each bit position, the reference is the strict majority of the array outputs at that position. An array whose bit differs from that majority gets its sticky error flag set. When a bit position has no strict majority, which can only happen with an even number of arrays, no single array can be blamed. In that case a sticky ambiguous flag is raised instead. A single fail output summarises all the flags. The test sequencer pulses the compare strobe on cycles where read data is valid. It clears the flags before a new test run.

Top module: `mutual_cmp`

## Requirements
- R1: After reset, every per-array error flag, the ambiguous flag and the fail output are 0.
- R2: Array k presents its word on rd_data_i[k*DATA_W +: DATA_W], and error flag k is arr_err_o[k]. On a strobed cycle, for each bit position with a strict majority (more than N_ARR/2 arrays agreeing), every array whose bit differs from that majority has its error flag set.
- R3: A strobed word that is identical across all arrays sets no error flag and does not set the ambiguous flag.
- R4: On a strobed cycle, a bit position with exactly N_ARR/2 ones sets the ambiguous flag. No array is blamed on account of that bit position.
- R5: When cmp_en_i is 0, read data has no effect on any flag.
- R6: Error and ambiguous flags are sticky: once set, they stay set until clr_i, whatever the later compared data.
- R7: clr_i clears all flags on the next edge and takes priority over a strobe in the same cycle. The data strobed in that cycle is discarded.
- R8: fail_o is 1 exactly when at least one error flag or the ambiguous flag is set.
- R9: Different arrays that deviate in different bit positions of the same word are all flagged in that one comparison.
- R10: Flags change on the first clock edge after the strobe or clear and are visible in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_data_i | input | N_ARR*DATA_W | Concatenated read words, array k in slice k |
| cmp_en_i | input | 1 | Compare strobe: data valid this cycle |
| clr_i | input | 1 | Clear all sticky flags |
| arr_err_o | output | N_ARR | Sticky per-array error flags |
| amb_o | output | 1 | Sticky flag for a bit position with no strict majority |
| fail_o | output | 1 | OR of all error flags and the ambiguous flag |

## Verification
The assertions assume that cmp_en_i and clr_i are driven to known levels every cycle after reset. They also assume that rd_data_i is steady around the capturing edge. The agreement assertion further assumes that a word identical across all arrays is a real agreement and not a common-mode fault. A common-mode fault is beyond what a consensus check can see. The bench drives every input on the falling edge and samples on the next falling edge, so the strobe and data are always stable at the rising edge. For each bit position it sweeps all sixteen column patterns of four arrays. It then runs long pseudo-random sequences with sparse deviations to exercise stickiness and the mix of strobe and clear.

// File: rtl/mutual_cmp_pkg.sv
package mutual_cmp_pkg;
  typedef enum logic [1:0] {
    VOTE_ZERO = 2'd0,
    VOTE_ONE  = 2'd1,
    VOTE_TIE  = 2'd2
  } vote_e;
endpackage

// File: rtl/mc_bit_vote.sv
module mc_bit_vote
  import mutual_cmp_pkg::*;
#(
  parameter int N_ARR = 4
) (
  input  logic [N_ARR-1:0] col_i,
  output logic [N_ARR-1:0] dev_o,
  output vote_e            vote_o
);
  localparam int CNT_W = $clog2(N_ARR + 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(N_ARR / 2);
  localparam logic [CNT_W-1:0] N_C    = CNT_W'(N_ARR);

  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] zeros;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_ARR; i++) ones = ones + CNT_W'(col_i[i]);
    zeros = N_C - ones;
  end

  always_comb begin
    if (ones > HALF_C)       vote_o = VOTE_ONE;
    else if (zeros > HALF_C) vote_o = VOTE_ZERO;
    else                     vote_o = VOTE_TIE;
  end

  always_comb begin
    for (int i = 0; i < N_ARR; i++) begin
      dev_o[i] = ((vote_o == VOTE_ONE) && !col_i[i]) ||
                 ((vote_o == VOTE_ZERO) && col_i[i]);
    end
  end
endmodule

// File: rtl/mc_flag_reg.sv
module mc_flag_reg #(
  parameter int N_ARR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_en_i,
  input  logic             clr_i,
  input  logic [N_ARR-1:0] dev_i,
  input  logic             tie_i,
  output logic [N_ARR-1:0] err_o,
  output logic             amb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= '0;
      amb_o <= 1'b0;
    end else if (clr_i) begin
      err_o <= '0;
      amb_o <= 1'b0;
    end else if (cmp_en_i) begin
      err_o <= err_o | dev_i;
      amb_o <= amb_o | tie_i;
    end
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_o == '0) && !amb_o); // R7

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((err_o & $past(err_o)) == $past(err_o)) && ($past(amb_o) -> amb_o)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !cmp_en_i) |=> $stable(err_o) && $stable(amb_o)); // R5
endmodule

// File: rtl/mutual_cmp.sv
module mutual_cmp
  import mutual_cmp_pkg::*;
#(
  parameter int N_ARR  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_ARR*DATA_W-1:0] rd_data_i,
  input  logic                    cmp_en_i,
  input  logic                    clr_i,
  output logic [N_ARR-1:0]        arr_err_o,
  output logic                    amb_o,
  output logic                    fail_o
);
  logic [N_ARR-1:0] col     [DATA_W];
  logic [N_ARR-1:0] dev_bit [DATA_W];
  vote_e            vote    [DATA_W];
  logic [N_ARR-1:0] dev_any;
  logic             tie_any;
  logic             all_eq;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    for (genvar a = 0; a < N_ARR; a++) begin : g_arr
      assign col[b][a] = rd_data_i[a*DATA_W + b];
    end
    mc_bit_vote #(.N_ARR(N_ARR)) u_vote (
      .col_i  (col[b]),
      .dev_o  (dev_bit[b]),
      .vote_o (vote[b])
    );
  end

  always_comb begin
    dev_any = '0;
    tie_any = 1'b0;
    for (int b = 0; b < DATA_W; b++) begin
      dev_any = dev_any | dev_bit[b];
      tie_any = tie_any | (vote[b] == VOTE_TIE);
    end
  end

  mc_flag_reg #(.N_ARR(N_ARR)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_en_i (cmp_en_i),
    .clr_i    (clr_i),
    .dev_i    (dev_any),
    .tie_i    (tie_any),
    .err_o    (arr_err_o),
    .amb_o    (amb_o)
  );

  assign fail_o = (|arr_err_o) | amb_o;

  // all arrays agree: used only by the agreement check below
  always_comb begin
    all_eq = 1'b1;
    for (int a = 1; a < N_ARR; a++)
      if (rd_data_i[a*DATA_W +: DATA_W] != rd_data_i[0 +: DATA_W]) all_eq = 1'b0;
  end

  AST_AGREE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && !clr_i && all_eq) |=> $stable(arr_err_o) && $stable(amb_o)); // R3

  AST_FAIL_SET_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(amb_o) |-> fail_o); // R8
endmodule

// File: tb/tb_mutual_cmp.sv
module tb_mutual_cmp;
  localparam int CLK_P  = 10;
  localparam int N_ARR  = 4;
  localparam int DATA_W = 8;
  localparam int TOT_W  = N_ARR * DATA_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [TOT_W-1:0] rd_data = '0;
  logic             cmp_en = 1'b0;
  logic             clr = 1'b0;
  logic [N_ARR-1:0] arr_err;
  logic             amb;
  logic             fail;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [N_ARR-1:0] exp_err = '0;
  logic             exp_amb = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mutual_cmp #(.N_ARR(N_ARR), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_data_i(rd_data), .cmp_en_i(cmp_en),
    .clr_i(clr), .arr_err_o(arr_err), .amb_o(amb), .fail_o(fail)
  );

  // majority model from the requirements: strict majority per bit, tie at N/2
  task automatic model(input logic [TOT_W-1:0] d, output logic [N_ARR-1:0] dv, output logic tie);
    dv = '0;
    tie = 1'b0;
    for (int b = 0; b < DATA_W; b++) begin
      int ones = 0;
      for (int a = 0; a < N_ARR; a++) ones += d[a*DATA_W + b];
      if (2*ones == N_ARR) tie = 1'b1;
      else begin
        for (int a = 0; a < N_ARR; a++)
          if (d[a*DATA_W + b] != (2*ones > N_ARR)) dv[a] = 1'b1;
      end
    end
  endtask

  task automatic check(input string req);
    checks++;
    if (arr_err !== exp_err || amb !== exp_amb) begin
      failures++;
      $display("FAIL %s: err=%b amb=%b expected err=%b amb=%b", req, arr_err, amb, exp_err, exp_amb);
    end
    checks++;
    if (fail !== ((|exp_err) | exp_amb)) begin
      failures++;
      $display("FAIL R8: fail=%b expected %b", fail, (|exp_err) | exp_amb);
    end
  endtask

  // one cycle: drive on falling edge, the rising edge captures, model updates
  task automatic cycle(input logic [TOT_W-1:0] d, input logic en, input logic cl);
    logic [N_ARR-1:0] dv;
    logic tie;
    @(negedge clk);
    rd_data = d;
    cmp_en = en;
    clr = cl;
    model(d, dv, tie);
    if (cl) begin
      exp_err = '0;
      exp_amb = 1'b0;
    end else if (en) begin
      exp_err = exp_err | dv;
      exp_amb = exp_amb | tie;
    end
    @(negedge clk);
  endtask

  function automatic logic [TOT_W-1:0] spread(input logic [DATA_W-1:0] base);
    logic [TOT_W-1:0] r;
    for (int a = 0; a < N_ARR; a++) r[a*DATA_W +: DATA_W] = base;
    return r;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [TOT_W-1:0] d;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    #(CLK_P*2 + 2);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2 R4: every column pattern on every bit position, other bits agree
    for (int b = 0; b < DATA_W; b++) begin
      for (int p = 0; p < (1 << N_ARR); p++) begin
        d = spread(DATA_W'(b*37 + p*11));
        for (int a = 0; a < N_ARR; a++) d[a*DATA_W + b] = p[a];
        cycle('0, 1'b0, 1'b1);
        cycle(d, 1'b1, 1'b0);
        check("R2/R4 sweep");
      end
    end

    // R3 unanimous words
    cycle('0, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      cycle(spread(DATA_W'(k*53 + 7)), 1'b1, 1'b0);
      check("R3");
    end

    // R10: flag visible one cycle after strobe, not before
    d = spread(8'hA5);
    d[2*DATA_W + 3] = ~d[2*DATA_W + 3];
    @(negedge clk);
    rd_data = d; cmp_en = 1'b1; clr = 1'b0;
    #1;
    checks++;
    if (arr_err !== 4'b0000) begin
      failures++;
      $display("FAIL R10: err=%b before edge expected 0000", arr_err);
    end
    @(negedge clk);
    exp_err = 4'b0100;
    check("R10");

    // R5: deviating data without strobe has no effect
    d = spread(8'h3C);
    d[0*DATA_W + 1] = ~d[0*DATA_W + 1];
    d[1*DATA_W + 1] = ~d[1*DATA_W + 1];
    cycle(d, 1'b0, 1'b0);
    check("R5");

    // R6: sticky across agreeing compares
    cycle(spread(8'h00), 1'b1, 1'b0);
    check("R6");

    // R9: two arrays deviate in different bits of one word
    cycle('0, 1'b0, 1'b1);
    d = spread(8'hF0);
    d[0*DATA_W + 0] = ~d[0*DATA_W + 0];
    d[3*DATA_W + 6] = ~d[3*DATA_W + 6];
    cycle(d, 1'b1, 1'b0);
    check("R9");
    checks++;
    if (arr_err !== 4'b1001) begin
      failures++;
      $display("FAIL R9: err=%b expected 1001", arr_err);
    end

    // R7: clear with strobe of a tie word discards the word
    d = spread(8'h00);
    d[0*DATA_W + 5] = 1'b1;
    d[1*DATA_W + 5] = 1'b1;
    cycle(d, 1'b1, 1'b1);
    check("R7");

    // random mixed sequences with sparse deviations, clear, idle
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      d = spread(lfsr[7:0]);
      if (lfsr[12]) d[lfsr[14:13]*DATA_W + lfsr[17:15]] ^= 1'b1;
      if (lfsr[18] && lfsr[19]) d[lfsr[21:20]*DATA_W + lfsr[24:22]] ^= 1'b1;
      cycle(d, lfsr[25] | lfsr[26], lfsr[27] & lfsr[28] & lfsr[29]);
      check("R6/R5/R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule